// File: doc/BRIEF.md
# Record Member Layout Engine

This engine computes where each member of a record lands in memory, as a compiler does when it lays out a structure. Members are presented one per handshake, in the order they are declared. Each member carries a byte size and an alignment. For every accepted member the engine returns two values. The first is the number of padding bytes placed in front of the member. The second is the byte offset at which the member starts.

When the member marked as final is accepted, the engine closes the record. It reports the record alignment, which is the largest effective alignment seen in the record. It also reports the total size, rounded up so that it is a multiple of that alignment.

An optional packing cap limits the alignment of each member to a chosen ceiling. A cap of one removes all padding. Alignment and cap values must be non-zero powers of two. Any other value is replaced by one, and the record's error flag is raised. If any address sum wraps past the 16-bit range, the record's overflow flag is raised.

The controller has three states:
- `ST_OPEN` waits for the first member of a record.
- `ST_FILL` takes the remaining members.
- `ST_CLOSE` is a single cycle in which the record result is presented and input is refused.

Its transitions are:
- OPEN→FILL on accepting a non-final member.
- OPEN→CLOSE or FILL→CLOSE on accepting the final member.
- CLOSE→OPEN unconditionally.

Top module: `record_layout_engine`

## Requirements
- R1: For each member, the padding equals (−offset) AND (effective alignment − 1), taken over 16 bits. The member offset is the running offset plus that padding. The running offset then advances by the member size. The first member of every record starts at running offset 0.
- R2: A member is accepted on a rising edge where `mbr_valid` and `mbr_ready` are both high. Its `res_pad` and `res_offset` appear with `res_valid` high in the cycle after acceptance. `res_valid` is low in any cycle that does not follow an acceptance.
- R3: `rec_align` equals the largest effective alignment among the record's members. It is always a power of two when `rec_done` is high.
- R4: `rec_size` equals the end of the final member rounded up to a multiple of `rec_align`, computed as (end + align − 1) AND NOT(align − 1).
- R5: When `cap_en` is high, a member's effective alignment is the smaller of its own alignment and `cap_value`. With `cap_value` = 1 no padding is inserted. When `cap_en` is low, `cap_value` has no effect.
- R6: An alignment or cap value that is zero or not a power of two is used as 1. `rec_error` is then high with that record's `rec_done`. Otherwise `rec_error` is low.
- R7: `rec_overflow` is high with `rec_done` if any of these 16-bit sums wraps within the record: offset plus padding, member offset plus size, or the final rounding. Sizes and offsets are reported modulo 2^16.
- R8: `rec_done` is a one-cycle pulse. It appears in the same cycle as the final member's result, and `mbr_ready` is low during that cycle. The following record starts from a cleared state: offset 0, alignment 1, and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbr_valid | input | 1 | A member is presented |
| mbr_ready | output | 1 | Engine can take a member (low in ST_CLOSE) |
| mbr_size | input | OFF_W | Member size in bytes |
| mbr_align | input | OFF_W | Member natural alignment (power of two) |
| mbr_last | input | 1 | Member is the final one of the record |
| cap_en | input | 1 | Enables the packing cap |
| cap_value | input | OFF_W | Packing cap (power of two) |
| res_valid | output | 1 | Per-member result valid |
| res_pad | output | OFF_W | Padding inserted before the member |
| res_offset | output | OFF_W | Byte offset of the member |
| rec_done | output | 1 | One-cycle record-complete pulse |
| rec_size | output | OFF_W | Total record size including tail padding |
| rec_align | output | OFF_W | Record alignment |
| rec_error | output | 1 | An invalid alignment or cap was seen in the record |
| rec_overflow | output | 1 | An address sum wrapped in the record |

## Verification
The final member's own result and the record-close result share one cycle. In that cycle `res_valid` and `rec_done` are both high, and `mbr_ready` drops. The bench provokes this with every record, including a record of a single member and records sent back to back, where the next record's first member must wait out the close cycle. The scoreboard pops the member queue and the record queue independently at the same sample point. It requires each `rec_done` to arrive together with the final member's offset and padding, and it requires the next record to restart at offset 0.

// File: rtl/rle_pkg.sv
package rle_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_FILL  = 2'd1,
        ST_CLOSE = 2'd2
    } rle_state_e;

endpackage

// File: rtl/rle_pow2_sanitize.sv
// Replaces a zero or non-power-of-two alignment with 1 and flags it.
module rle_pow2_sanitize #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean,
    output logic         bad
);

    always_comb begin
        bad   = (raw == '0) || ((raw & (raw - W'(1))) != '0);
        clean = bad ? W'(1) : raw;
    end

endmodule

// File: rtl/rle_pad_unit.sv
// Padding, member placement and member end for one member.
module rle_pad_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_off,
    input  logic [W-1:0] align,
    input  logic [W-1:0] size,
    output logic [W-1:0] pad,
    output logic [W-1:0] member_off,
    output logic [W-1:0] member_end,
    output logic         carry
);

    logic [W:0] placed_full;
    logic [W:0] end_full;

    always_comb begin
        pad         = (~cur_off + W'(1)) & (align - W'(1));
        placed_full = {1'b0, cur_off} + {1'b0, pad};
        member_off  = placed_full[W-1:0];
        end_full    = {1'b0, member_off} + {1'b0, size};
        member_end  = end_full[W-1:0];
        carry       = placed_full[W] | end_full[W];
    end

endmodule

// File: rtl/rle_round_unit.sv
// Rounds a byte count up to a power-of-two multiple.
module rle_round_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] end_val,
    input  logic [W-1:0] align,
    output logic [W-1:0] rounded,
    output logic         carry
);

    logic [W:0] biased;
    logic [W:0] mask;
    logic [W:0] full;

    always_comb begin
        biased  = {1'b0, end_val} + {1'b0, align} - (W+1)'(1);
        mask    = ~{1'b0, align - W'(1)};
        full    = biased & mask;
        rounded = full[W-1:0];
        carry   = full[W];
    end

endmodule

// File: rtl/record_layout_engine.sv
module record_layout_engine
    import rle_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbr_valid,
    output logic             mbr_ready,
    input  logic [OFF_W-1:0] mbr_size,
    input  logic [OFF_W-1:0] mbr_align,
    input  logic             mbr_last,
    input  logic             cap_en,
    input  logic [OFF_W-1:0] cap_value,
    output logic             res_valid,
    output logic [OFF_W-1:0] res_pad,
    output logic [OFF_W-1:0] res_offset,
    output logic             rec_done,
    output logic [OFF_W-1:0] rec_size,
    output logic [OFF_W-1:0] rec_align,
    output logic             rec_error,
    output logic             rec_overflow
);

    rle_state_e state_q, state_d;

    logic [OFF_W-1:0] cur_off_q;
    logic [OFF_W-1:0] max_al_q;
    logic             err_acc_q;
    logic             ovf_acc_q;

    logic             accept;
    logic [OFF_W-1:0] al_clean, cap_clean, eff_al, rec_al_next;
    logic             al_bad, cap_bad, cfg_bad;
    logic [OFF_W-1:0] pad_w, moff_w, mend_w, rsize_w;
    logic             pad_carry, round_carry;

    assign mbr_ready = (state_q != ST_CLOSE);
    assign accept    = mbr_valid && mbr_ready;

    rle_pow2_sanitize #(.W(OFF_W)) i_align_clean (
        .raw   (mbr_align),
        .clean (al_clean),
        .bad   (al_bad)
    );

    rle_pow2_sanitize #(.W(OFF_W)) i_cap_clean (
        .raw   (cap_value),
        .clean (cap_clean),
        .bad   (cap_bad)
    );

    always_comb begin
        eff_al      = (cap_en && (cap_clean < al_clean)) ? cap_clean : al_clean;
        cfg_bad     = al_bad || (cap_en && cap_bad);
        rec_al_next = (eff_al > max_al_q) ? eff_al : max_al_q;
    end

    rle_pad_unit #(.W(OFF_W)) i_pad (
        .cur_off    (cur_off_q),
        .align      (eff_al),
        .size       (mbr_size),
        .pad        (pad_w),
        .member_off (moff_w),
        .member_end (mend_w),
        .carry      (pad_carry)
    );

    rle_round_unit #(.W(OFF_W)) i_round (
        .end_val (mend_w),
        .align   (rec_al_next),
        .rounded (rsize_w),
        .carry   (round_carry)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN, ST_FILL: begin
                if (accept) state_d = mbr_last ? ST_CLOSE : ST_FILL;
            end
            ST_CLOSE: state_d = ST_OPEN;
            default:  state_d = ST_OPEN;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_off_q    <= '0;
            max_al_q     <= OFF_W'(1);
            err_acc_q    <= 1'b0;
            ovf_acc_q    <= 1'b0;
            res_valid    <= 1'b0;
            res_pad      <= '0;
            res_offset   <= '0;
            rec_done     <= 1'b0;
            rec_size     <= '0;
            rec_align    <= OFF_W'(1);
            rec_error    <= 1'b0;
            rec_overflow <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            rec_done  <= 1'b0;
            if (accept) begin
                res_valid  <= 1'b1;
                res_pad    <= pad_w;
                res_offset <= moff_w;
                if (mbr_last) begin
                    rec_done     <= 1'b1;
                    rec_size     <= rsize_w;
                    rec_align    <= rec_al_next;
                    rec_error    <= err_acc_q || cfg_bad;
                    rec_overflow <= ovf_acc_q || pad_carry || round_carry;
                    cur_off_q    <= '0;
                    max_al_q     <= OFF_W'(1);
                    err_acc_q    <= 1'b0;
                    ovf_acc_q    <= 1'b0;
                end else begin
                    cur_off_q <= mend_w;
                    max_al_q  <= rec_al_next;
                    err_acc_q <= err_acc_q || cfg_bad;
                    ovf_acc_q <= ovf_acc_q || pad_carry;
                end
            end
        end
    end

endmodule

// File: rtl/record_layout_checks.sv
module record_layout_checks #(
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mbr_valid,
    input logic             mbr_ready,
    input logic             res_valid,
    input logic             rec_done,
    input logic [OFF_W-1:0] rec_size,
    input logic [OFF_W-1:0] rec_align,
    input logic             rec_overflow
);

    logic take;
    assign take = mbr_valid && mbr_ready;

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) take |=> res_valid); // R2
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !take |=> !res_valid); // R2
    AST_ALIGN_POW2: assert property (@(posedge clk) disable iff (!rst_n) rec_done |-> ($countones(rec_align) == 1)); // R3
    AST_SIZE_MULTIPLE: assert property (@(posedge clk) disable iff (!rst_n) (rec_done && !rec_overflow) |-> ((rec_size & (rec_align - OFF_W'(1))) == '0)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rec_done |=> !rec_done); // R8
    AST_DONE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n) rec_done |-> res_valid); // R8
    AST_DONE_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) rec_done |-> !mbr_ready); // R8

endmodule

bind record_layout_engine record_layout_checks #(.OFF_W(OFF_W)) i_layout_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .mbr_valid    (mbr_valid),
    .mbr_ready    (mbr_ready),
    .res_valid    (res_valid),
    .rec_done     (rec_done),
    .rec_size     (rec_size),
    .rec_align    (rec_align),
    .rec_overflow (rec_overflow)
);

// File: tb/test_record_layout_engine.sv
module test_record_layout_engine;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mbr_valid = 1'b0;
    logic         mbr_ready;
    logic [W-1:0] mbr_size = '0;
    logic [W-1:0] mbr_align = '0;
    logic         mbr_last = 1'b0;
    logic         cap_en = 1'b0;
    logic [W-1:0] cap_value = '0;
    logic         res_valid;
    logic [W-1:0] res_pad, res_offset;
    logic         rec_done;
    logic [W-1:0] rec_size, rec_align;
    logic         rec_error, rec_overflow;

    always #2 clk = ~clk;

    record_layout_engine #(.OFF_W(W)) i_record_layout_engine (
        .clk(clk), .rst_n(rst_n), .mbr_valid(mbr_valid), .mbr_ready(mbr_ready),
        .mbr_size(mbr_size), .mbr_align(mbr_align), .mbr_last(mbr_last),
        .cap_en(cap_en), .cap_value(cap_value), .res_valid(res_valid),
        .res_pad(res_pad), .res_offset(res_offset), .rec_done(rec_done),
        .rec_size(rec_size), .rec_align(rec_align), .rec_error(rec_error),
        .rec_overflow(rec_overflow)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int    q_pad[$];
    int    q_off[$];
    string q_mtag[$];
    int    q_size[$];
    int    q_al[$];
    bit    q_err[$];
    bit    q_ovf[$];
    string q_rtag[$];

    int m_off = 0;
    int m_al = 1;
    bit m_err = 0;
    bit m_ovf = 0;

    function automatic bit is_p2(int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic send(int size, int align, bit last, bit cen, int cval, string tag);
        int a, c, eff, pad, mo, me, rs;
        @(negedge clk);
        mbr_valid = 1'b1;
        mbr_size  = W'(size);
        mbr_align = W'(align);
        mbr_last  = last;
        cap_en    = cen;
        cap_value = W'(cval);
        while (!mbr_ready) @(negedge clk);
        a = is_p2(align) ? align : 1;
        if (!is_p2(align)) m_err = 1;
        eff = a;
        if (cen) begin
            c = is_p2(cval) ? cval : 1;
            if (!is_p2(cval)) m_err = 1;
            if (c < eff) eff = c;
        end
        pad = (eff - (m_off % eff)) % eff;
        mo  = m_off + pad;
        if (mo > 65535) m_ovf = 1;
        mo  = mo % 65536;
        me  = mo + size;
        if (me > 65535) m_ovf = 1;
        me  = me % 65536;
        if (eff > m_al) m_al = eff;
        q_pad.push_back(pad);
        q_off.push_back(mo);
        q_mtag.push_back(tag);
        if (last) begin
            rs = ((me + m_al - 1) / m_al) * m_al;
            if (rs > 65535) m_ovf = 1;
            q_size.push_back(rs % 65536);
            q_al.push_back(m_al);
            q_err.push_back(m_err);
            q_ovf.push_back(m_ovf);
            q_rtag.push_back(tag);
            m_off = 0; m_al = 1; m_err = 0; m_ovf = 0;
        end else begin
            m_off = me;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        mbr_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                if (q_pad.size() == 0) begin
                    check(0, "R2", "unexpected member result", 1, 0);
                end else begin
                    string t;
                    int ep, eo;
                    ep = q_pad.pop_front();
                    eo = q_off.pop_front();
                    t  = q_mtag.pop_front();
                    check(res_pad == W'(ep), t, "pad", int'(res_pad), ep);
                    check(res_offset == W'(eo), t, "offset", int'(res_offset), eo);
                end
            end
            if (rec_done) begin
                if (q_size.size() == 0) begin
                    check(0, "R8", "unexpected done", 1, 0);
                end else begin
                    string t;
                    int es, ea;
                    bit ee, eov;
                    es  = q_size.pop_front();
                    ea  = q_al.pop_front();
                    ee  = q_err.pop_front();
                    eov = q_ovf.pop_front();
                    t   = q_rtag.pop_front();
                    check(rec_size == W'(es), t, "rec_size", int'(rec_size), es);
                    check(rec_align == W'(ea), t, "rec_align", int'(rec_align), ea);
                    check(rec_error == ee, t, "rec_error", int'(rec_error), int'(ee));
                    check(rec_overflow == eov, t, "rec_overflow", int'(rec_overflow), int'(eov));
                    check(res_valid, "R8", "done without final member result", int'(res_valid), 1);
                    check(!mbr_ready, "R8", "ready during close", int'(mbr_ready), 0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R2", "reset res_valid", int'(res_valid), 0);
        check(rec_done == 1'b0, "R8", "reset rec_done", int'(rec_done), 0);
        check(mbr_ready == 1'b1, "R8", "reset mbr_ready", int'(mbr_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4: sizes 1,2,4,1 natural; cap disabled with cap_value 1 (R5 ignored)
        send(1, 1, 0, 0, 1, "R1");
        send(2, 2, 0, 0, 1, "R1");
        send(4, 4, 0, 0, 1, "R5");
        send(1, 1, 1, 0, 1, "R4");
        // back to back: reordered 1,1,2,4 -> size 8 (R8 restart from offset 0)
        send(1, 1, 0, 0, 0, "R8");
        send(1, 1, 0, 0, 0, "R1");
        send(2, 2, 0, 0, 0, "R1");
        send(4, 4, 1, 0, 0, "R3");
        idle();
        // R5: cap 1 -> size 6, align 1
        send(1, 1, 0, 1, 1, "R5");
        send(4, 4, 0, 1, 1, "R5");
        send(1, 1, 1, 1, 1, "R5");
        // R4 tail: 4 then 1 -> 8
        send(4, 4, 0, 0, 0, "R4");
        send(1, 1, 1, 0, 0, "R4");
        // R4: 2 then 3-byte array of align 1 -> 6
        send(2, 2, 0, 0, 0, "R4");
        send(3, 1, 1, 0, 0, "R4");
        idle();
        // R5: cap 2 with an 8-byte member -> 12
        send(1, 1, 0, 1, 2, "R5");
        send(8, 8, 0, 1, 2, "R5");
        send(1, 1, 1, 1, 2, "R5");
        // R6: align 3 and align 0 treated as 1
        send(1, 1, 0, 0, 0, "R6");
        send(4, 3, 0, 0, 0, "R6");
        send(2, 0, 1, 0, 0, "R6");
        // R6: invalid cap with valid alignment
        send(1, 1, 0, 1, 6, "R6");
        send(4, 4, 1, 1, 6, "R6");
        // R3 clean record after error: single member, tail rounding 3 -> 4
        send(3, 2, 1, 0, 0, "R3");
        // R7: wrap
        send(16'hFFF0, 1, 0, 0, 0, "R7");
        send(16'h0020, 1, 1, 0, 0, "R7");
        // R7: padding wrap
        send(16'hFFFF, 1, 0, 0, 0, "R7");
        send(2, 2, 1, 0, 0, "R7");
        // R8: a clean record after overflow
        send(2, 2, 0, 0, 0, "R8");
        send(8, 8, 1, 0, 0, "R8");
        idle();
        repeat (5) @(negedge clk);
        check(q_pad.size() == 0, "R2", "member results missing", q_pad.size(), 0);
        check(q_size.size() == 0, "R8", "record results missing", q_size.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule